// File: doc/BRIEF.md
# RV32C Instruction Expander

This stage widens one 16-bit compressed RISC-V instruction into the 32-bit RV32I instruction that does the same work. A decode stage can then handle a single instruction format. The integer subset is covered: stack-relative and register-based word loads and stores, immediate and register-register arithmetic, jumps, branches, moves and breakpoint. Words outside that subset are marked illegal. This includes the floating-point forms, the forms that exist only on 64/128-bit cores, and reserved points of the encoding space.

A word whose two low bits are 11 is already a full-width instruction. The stage passes it through and takes its upper half from a second input. A flag tells the next stage whether the word came from a compressed form, so it can step the PC by 2 and form links as PC+2. By default the result is registered: it appears one clock after the input is presented, together with a valid bit that follows the input valid. A parameter selects a purely combinational build instead.

Top module: `rvc_expand_stage`

## Requirements
- R1: When in_half[1:0] is 11, out_word equals {in_upper, in_half}, out_compressed is 0 and out_illegal is 0.
- R2: With the default registered build, out_valid, out_word, out_illegal and out_compressed show the result for the input sampled at the previous rising clock edge. out_valid equals the in_valid sampled there. out_compressed is 1 for every input whose low two bits are not 11.
- R3: The 3-bit register fields of the compact forms name x8..x15, so field value n becomes register index n+8.
- R4: Quadrant 00 funct3 000 expands to addi rd', x2, imm. The unsigned immediate takes imm[5:4] from bits 12:11, imm[9:6] from bits 10:7, imm[2] from bit 6 and imm[3] from bit 5. A zero immediate is illegal, and so is the all-zero halfword.
- R5: Quadrant 00 funct3 010 gives lw and funct3 110 gives sw. The zero-extended offset takes [5:3] from bits 12:10, [2] from bit 6 and [6] from bit 5. The base is bits 9:7 and the data register is bits 4:2.
- R6: Quadrant 01 funct3 101 gives jal x0 and funct3 001 gives jal x1. The signed offset maps bit12→11, bit11→4, bits10:9→9:8, bit8→10, bit7→6, bit6→7, bits5:3→3:1 and bit2→5.
- R7: Quadrant 01 funct3 110 gives beq rs1', x0 and funct3 111 gives bne rs1', x0. The signed offset maps bit12→8, bits11:10→4:3, bits6:5→7:6, bits4:3→2:1 and bit2→5.
- R8: Quadrant 01 funct3 011 with rd (bits 11:7) equal to 2 gives addi x2, x2, imm. Its signed immediate maps bit12→9, bit6→4, bit5→6, bits4:3→8:7 and bit2→5. Any other rd gives lui rd with a sign-extended 6-bit upper immediate (bit12 and bits 6:2). That lui form is illegal when rd is 0 or the immediate is 0.
- R9: Quadrant 10 funct3 100 is resolved by precedence. With bit12 = 0, rs2 (bits 6:2) = 0 gives jalr x0, 0(rs1), and otherwise add rd, x0, rs2. With bit12 = 1, rd = 0 and rs2 = 0 gives ebreak (0x00100073), rs2 = 0 alone gives jalr x1, 0(rs1), and otherwise add rd, rd, rs2.
- R10: The load-immediate form (quadrant 01 funct3 010) expands to addi rd, x0, imm and is illegal with rd = 0. The shift-left form (quadrant 10 funct3 000) expands to slli and is illegal with rd = 0.
- R11: Quadrant 10 funct3 010 gives lw rd, off(x2), with offset [5] from bit 12, [4:2] from bits 6:4 and [7:6] from bits 3:2. Quadrant 10 funct3 110 gives sw rs2, off(x2), with offset [5:2] from bits 12:9 and [7:6] from bits 8:7. Both offsets are zero-extended.
- R12: Every illegal input gives out_illegal = 1 and out_word = 0. Illegal inputs include quadrant 00 funct3 001/011/100/101/111, quadrant 10 funct3 001/011/101/111, and quadrant 01 funct3 100 with bit12 = 1 and bits 11:10 = 11. They also include the 32-bit-only shift forms, which have bit12 = 1.
- R13: Quadrant 01 funct3 000 gives addi and funct3 100 gives the compact arithmetic. Bits 11:10 pick srli (00), srai (01) or andi (10); with 11, bits 6:5 pick sub, xor, or, and. Immediates are 6-bit sign-extended and shift amounts are bits 6:2.
- R14: While rst_n is low at a clock edge, all registered outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_half | input | 16 | Compressed word, or lower half of a full word |
| in_upper | input | 16 | Upper half used when the word is not compressed |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 32 | Expanded or passed-through instruction |
| out_illegal | output | 1 | Input was illegal or reserved |
| out_compressed | output | 1 | Input was a 16-bit form |

## Verification
Each scrambled immediate is driven with values whose bits differ from one another, and with the sign bit both set and clear. A field wired from the wrong source bit, or with its sign extension dropped, therefore produces a different target or offset. The overlapping encodings are each hit at the exact register values that switch them: rd of 2 in the upper-immediate slot, and rd or rs2 of zero in the move/add slot. A wrong precedence there would emit lui instead of the stack adjust, or a move instead of a jump-register or breakpoint. The illegal cases check that the word itself is zeroed, so a design that only raises the flag while leaking a half-decoded word is caught. The full-width pass-through checks that the upper half really comes from the second input.

// File: rtl/rvc_pkg.sv
// Package: shared widths, RV32I opcodes and instruction-format builders.
// Assumes: callers supply fields already in target bit order.
package rvc_pkg;
    localparam int CW = 16;
    localparam int IW = 32;
    localparam int RW = 5;

    localparam logic [6:0] OP_LOAD   = 7'b0000011;
    localparam logic [6:0] OP_STORE  = 7'b0100011;
    localparam logic [6:0] OP_IMM    = 7'b0010011;
    localparam logic [6:0] OP_REG    = 7'b0110011;
    localparam logic [6:0] OP_LUI    = 7'b0110111;
    localparam logic [6:0] OP_BRANCH = 7'b1100011;
    localparam logic [6:0] OP_JALR   = 7'b1100111;
    localparam logic [6:0] OP_JAL    = 7'b1101111;
    localparam logic [IW-1:0] WORD_EBREAK = 32'h0010_0073;

    localparam logic [RW-1:0] REG_ZERO = 5'd0;
    localparam logic [RW-1:0] REG_RA   = 5'd1;
    localparam logic [RW-1:0] REG_SP   = 5'd2;

    // Result of one quadrant decoder.
    typedef struct packed {
        logic [IW-1:0] word;
        logic          bad;
    } xlat_t;

    // I-type word.
    function automatic logic [IW-1:0] mk_i(logic [11:0] imm, logic [RW-1:0] rs1,
                                          logic [2:0] f3, logic [RW-1:0] rd, logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    // S-type word.
    function automatic logic [IW-1:0] mk_s(logic [11:0] imm, logic [RW-1:0] rs2,
                                          logic [RW-1:0] rs1, logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
    endfunction

    // B-type word from a 13-bit byte offset.
    function automatic logic [IW-1:0] mk_b(logic [12:0] imm, logic [RW-1:0] rs1, logic [2:0] f3);
        return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OP_BRANCH};
    endfunction

    // J-type word from a 21-bit byte offset.
    function automatic logic [IW-1:0] mk_j(logic [20:0] imm, logic [RW-1:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OP_JAL};
    endfunction

    // R-type word.
    function automatic logic [IW-1:0] mk_r(logic [6:0] f7, logic [RW-1:0] rs2, logic [RW-1:0] rs1,
                                          logic [2:0] f3, logic [RW-1:0] rd);
        return {f7, rs2, rs1, f3, rd, OP_REG};
    endfunction

    // Expand a 3-bit compact register field to x8..x15.
    function automatic logic [RW-1:0] creg(logic [2:0] f);
        return {2'b01, f};
    endfunction
endpackage

// File: rtl/rvc_q0_dec.sv
// Quadrant 00 decoder: stack-pointer add into register, compact word load/store.
// Assumes: input bits [1:0] are 00 (checked by the parent); floating-point and
// wide forms in this quadrant are reported as bad.
module rvc_q0_dec
    import rvc_pkg::*;
(
    input  logic [CW-1:2] cw,
    output xlat_t         res
);
    logic [9:0] spn_imm;
    logic [6:0] mem_off;

    // Unscramble the immediates of this quadrant.
    always_comb begin
        spn_imm = {cw[10:7], cw[12:11], cw[5], cw[6], 2'b00};
        mem_off = {cw[5], cw[12:10], cw[6], 2'b00};
    end

    // Select the expansion by funct3.
    always_comb begin
        res = '0;
        unique case (cw[15:13])
            3'b000: begin
                res.word = mk_i({2'b00, spn_imm}, REG_SP, 3'b000, creg(cw[4:2]), OP_IMM);
                res.bad  = (spn_imm == 10'd0);
            end
            3'b010: res.word = mk_i({5'd0, mem_off}, creg(cw[9:7]), 3'b010, creg(cw[4:2]), OP_LOAD);
            3'b110: res.word = mk_s({5'd0, mem_off}, creg(cw[4:2]), creg(cw[9:7]), 3'b010);
            default: res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/rvc_q1_dec.sv
// Quadrant 01 decoder: immediate arithmetic, jumps, branches, upper immediate,
// stack adjust and compact register arithmetic.
// Assumes: input bits [1:0] are 01; forms only valid on wider cores are bad.
module rvc_q1_dec
    import rvc_pkg::*;
(
    input  logic [CW-1:2] cw,
    output xlat_t         res
);
    logic [RW-1:0] rd_full;
    logic [RW-1:0] rd_cmp;
    logic [RW-1:0] rs2_cmp;
    logic [11:0]   imm6_sx;
    logic [20:0]   jmp_off;
    logic [12:0]   br_off;
    logic [11:0]   sp_off;
    logic [19:0]   upper;
    logic [2:0]    logic_f3;

    // Field extraction and immediate unscrambling.
    always_comb begin
        rd_full = cw[11:7];
        rd_cmp  = creg(cw[9:7]);
        rs2_cmp = creg(cw[4:2]);
        imm6_sx = {{6{cw[12]}}, cw[12], cw[6:2]};
        jmp_off = {{10{cw[12]}}, cw[8], cw[10:9], cw[6], cw[7], cw[2], cw[11], cw[5:3], 1'b0};
        br_off  = {{5{cw[12]}}, cw[6:5], cw[2], cw[11:10], cw[4:3], 1'b0};
        sp_off  = {{3{cw[12]}}, cw[4:3], cw[5], cw[2], cw[6], 4'b0000};
        upper   = {{14{cw[12]}}, cw[12], cw[6:2]};
    end

    // funct3 for the register-register logic group, picked by bits 6:5.
    always_comb begin
        unique case (cw[6:5])
            2'b00:   logic_f3 = 3'b000;
            2'b01:   logic_f3 = 3'b100;
            2'b10:   logic_f3 = 3'b110;
            default: logic_f3 = 3'b111;
        endcase
    end

    // Select the expansion by funct3 and sub-fields.
    always_comb begin
        res = '0;
        unique case (cw[15:13])
            3'b000: res.word = mk_i(imm6_sx, rd_full, 3'b000, rd_full, OP_IMM);
            3'b001: res.word = mk_j(jmp_off, REG_RA);
            3'b010: begin
                res.word = mk_i(imm6_sx, REG_ZERO, 3'b000, rd_full, OP_IMM);
                res.bad  = (rd_full == REG_ZERO);
            end
            3'b011: begin
                if (rd_full == REG_SP) begin
                    res.word = mk_i(sp_off, REG_SP, 3'b000, REG_SP, OP_IMM);
                end else begin
                    res.word = {upper, rd_full, OP_LUI};
                    res.bad  = (rd_full == REG_ZERO) || ({cw[12], cw[6:2]} == 6'd0);
                end
            end
            3'b100: begin
                unique case (cw[11:10])
                    2'b00: begin
                        res.word = mk_i({7'b0000000, cw[6:2]}, rd_cmp, 3'b101, rd_cmp, OP_IMM);
                        res.bad  = cw[12];
                    end
                    2'b01: begin
                        res.word = mk_i({7'b0100000, cw[6:2]}, rd_cmp, 3'b101, rd_cmp, OP_IMM);
                        res.bad  = cw[12];
                    end
                    2'b10: res.word = mk_i(imm6_sx, rd_cmp, 3'b111, rd_cmp, OP_IMM);
                    default: begin
                        res.word = mk_r((cw[6:5] == 2'b00) ? 7'b0100000 : 7'b0000000,
                                        rs2_cmp, rd_cmp, logic_f3, rd_cmp);
                        res.bad  = cw[12];
                    end
                endcase
            end
            3'b101: res.word = mk_j(jmp_off, REG_ZERO);
            3'b110: res.word = mk_b(br_off, rd_cmp, 3'b000);
            default: res.word = mk_b(br_off, rd_cmp, 3'b001);
        endcase
    end
endmodule

// File: rtl/rvc_q2_dec.sv
// Quadrant 10 decoder: shift-left, stack-relative load/store, and the
// jump-register / move / breakpoint / link-jump / add group.
// Assumes: input bits [1:0] are 10; floating-point and wide forms are bad.
module rvc_q2_dec
    import rvc_pkg::*;
(
    input  logic [CW-1:2] cw,
    output xlat_t         res
);
    logic [RW-1:0] rd_full;
    logic [RW-1:0] rs2_full;
    logic [7:0]    ld_off;
    logic [7:0]    st_off;

    // Field extraction and offset unscrambling.
    always_comb begin
        rd_full  = cw[11:7];
        rs2_full = cw[6:2];
        ld_off   = {cw[3:2], cw[12], cw[6:4], 2'b00};
        st_off   = {cw[8:7], cw[12:9], 2'b00};
    end

    // Select the expansion; the funct3 100 group uses fixed precedence.
    always_comb begin
        res = '0;
        unique case (cw[15:13])
            3'b000: begin
                res.word = mk_i({7'b0000000, rs2_full}, rd_full, 3'b001, rd_full, OP_IMM);
                res.bad  = cw[12] || (rd_full == REG_ZERO);
            end
            3'b010: res.word = mk_i({4'd0, ld_off}, REG_SP, 3'b010, rd_full, OP_LOAD);
            3'b100: begin
                if (!cw[12]) begin
                    if (rs2_full == REG_ZERO) res.word = mk_i(12'd0, rd_full, 3'b000, REG_ZERO, OP_JALR);
                    else                      res.word = mk_r(7'd0, rs2_full, REG_ZERO, 3'b000, rd_full);
                end else begin
                    if (rs2_full == REG_ZERO && rd_full == REG_ZERO) res.word = WORD_EBREAK;
                    else if (rs2_full == REG_ZERO) res.word = mk_i(12'd0, rd_full, 3'b000, REG_RA, OP_JALR);
                    else                           res.word = mk_r(7'd0, rs2_full, rd_full, 3'b000, rd_full);
                end
            end
            3'b110: res.word = mk_s({4'd0, st_off}, rs2_full, REG_SP, 3'b010);
            default: res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/rvc_expand_stage.sv
// Top: routes the halfword to its quadrant decoder, passes full-width words
// through, zeroes illegal results and (REG_OUT=1) registers the outputs.
// Assumes: one instruction per cycle; synchronous active-low reset.
module rvc_expand_stage
    import rvc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_half,
    input  logic [CW-1:0] in_upper,
    output logic          out_valid,
    output logic [IW-1:0] out_word,
    output logic          out_illegal,
    output logic          out_compressed
);
    xlat_t         q0_res, q1_res, q2_res, pick;
    logic [IW-1:0] nxt_word;
    logic          nxt_bad;
    logic          nxt_comp;

    rvc_q0_dec u_q0 (.cw(in_half[CW-1:2]), .res(q0_res));
    rvc_q1_dec u_q1 (.cw(in_half[CW-1:2]), .res(q1_res));
    rvc_q2_dec u_q2 (.cw(in_half[CW-1:2]), .res(q2_res));

    // Quadrant select, pass-through and illegal zeroing.
    always_comb begin
        unique case (in_half[1:0])
            2'b00:   pick = q0_res;
            2'b01:   pick = q1_res;
            2'b10:   pick = q2_res;
            default: pick = '{word: {in_upper, in_half}, bad: 1'b0};
        endcase
        nxt_comp = (in_half[1:0] != 2'b11);
        nxt_bad  = pick.bad;
        nxt_word = pick.bad ? '0 : pick.word;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register stage with synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid      <= 1'b0;
                    out_word       <= '0;
                    out_illegal    <= 1'b0;
                    out_compressed <= 1'b0;
                end else begin
                    out_valid      <= in_valid;
                    out_word       <= nxt_word;
                    out_illegal    <= nxt_bad;
                    out_compressed <= nxt_comp;
                end
            end
        end else begin : g_comb
            // Combinational build: outputs follow the inputs directly.
            always_comb begin
                out_valid      = in_valid;
                out_word       = nxt_word;
                out_illegal    = nxt_bad;
                out_compressed = nxt_comp;
            end
        end
    endgenerate
endmodule

// File: rtl/rvc_expand_check.sv
// Checker bound to rvc_expand_stage: port-level properties over time.
module rvc_expand_check
    import rvc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [CW-1:0] in_half,
    input logic [CW-1:0] in_upper,
    input logic          out_valid,
    input logic [IW-1:0] out_word,
    input logic          out_illegal,
    input logic          out_compressed
);
    AST_ILLEGAL_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_word == '0); // R12

    AST_EXPANDED_IS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_compressed && !out_illegal) |-> out_word[1:0] == 2'b11); // R2

    generate
        if (REG_OUT) begin : g_seq
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R2

            AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
                (in_half[1:0] == 2'b11) |=>
                    (!out_compressed && !out_illegal && out_word == {$past(in_upper), $past(in_half)})); // R1

            AST_ZERO_HALF_BAD: assert property (@(posedge clk) disable iff (!rst_n)
                (in_half == 16'h0000) |=> out_illegal); // R4

            AST_BREAKPOINT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_half == 16'h9002) |=> out_word == WORD_EBREAK); // R9
        end
    endgenerate
endmodule

bind rvc_expand_stage rvc_expand_check #(.REG_OUT(REG_OUT)) u_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .in_upper(in_upper), .out_valid(out_valid), .out_word(out_word),
    .out_illegal(out_illegal), .out_compressed(out_compressed)
);

// File: tb/test_rvc_expand_stage.sv
// Directed bench for rvc_expand_stage: builds compressed words from chosen
// fields and compares against RV32I words built from the requirements.
module test_rvc_expand_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic [15:0] in_upper = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_illegal;
    logic        out_compressed;
    int          n_run = 0;
    int          n_fail = 0;

    localparam logic [6:0] LD = 7'b0000011, ST = 7'b0100011, OI = 7'b0010011,
                           OR = 7'b0110011, LU = 7'b0110111, BR = 7'b1100011,
                           JR = 7'b1100111, JL = 7'b1101111;

    always #5 clk = ~clk;

    rvc_expand_stage i_rvc_expand_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
        .in_upper(in_upper), .out_valid(out_valid), .out_word(out_word),
        .out_illegal(out_illegal), .out_compressed(out_compressed)
    );

    // Expected RV32I encoders.
    function automatic logic [31:0] e_i(logic [11:0] i, logic [4:0] a, logic [2:0] f, logic [4:0] d, logic [6:0] o);
        return {i, a, f, d, o};
    endfunction
    function automatic logic [31:0] e_s(logic [11:0] i, logic [4:0] b, logic [4:0] a);
        return {i[11:5], b, a, 3'b010, i[4:0], ST};
    endfunction
    function automatic logic [31:0] e_b(logic [12:0] i, logic [4:0] a, logic [2:0] f);
        return {i[12], i[10:5], 5'd0, a, f, i[4:1], i[11], BR};
    endfunction
    function automatic logic [31:0] e_j(logic [20:0] i, logic [4:0] d);
        return {i[20], i[10:1], i[11], i[19:12], d, JL};
    endfunction
    function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a, logic [2:0] f, logic [4:0] d);
        return {f7, b, a, f, d, OR};
    endfunction

    // Compressed word builders (scramble chosen fields into place).
    function automatic logic [15:0] c_spn(logic [9:0] i, logic [2:0] d);
        return {3'b000, i[5:4], i[9:6], i[2], i[3], d, 2'b00};
    endfunction
    function automatic logic [15:0] c_mem(logic [2:0] f, logic [6:0] o, logic [2:0] a, logic [2:0] d);
        return {f, o[5:3], a, o[2], o[6], d, 2'b00};
    endfunction
    function automatic logic [15:0] c_jmp(logic [2:0] f, logic [11:0] i);
        return {f, i[11], i[4], i[9:8], i[10], i[6], i[7], i[3:1], i[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_br(logic [2:0] f, logic [8:0] i, logic [2:0] a);
        return {f, i[8], i[4:3], a, i[7:6], i[2:1], i[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_sp16(logic [9:0] i);
        return {3'b011, i[9], 5'd2, i[4], i[6], i[8:7], i[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_ci(logic [2:0] f, logic b12, logic [4:0] r, logic [4:0] lo, logic [1:0] q);
        return {f, b12, r, lo, q};
    endfunction
    function automatic logic [15:0] c_ar(logic b12, logic [1:0] f2, logic [2:0] r, logic [4:0] lo);
        return {3'b100, b12, f2, r, lo, 2'b01};
    endfunction
    function automatic logic [15:0] c_lwsp(logic [7:0] o, logic [4:0] d);
        return {3'b010, o[5], d, o[4:2], o[7:6], 2'b10};
    endfunction
    function automatic logic [15:0] c_swsp(logic [7:0] o, logic [4:0] b);
        return {3'b110, o[5:2], o[7:6], b, 2'b10};
    endfunction

    // Present one word, wait one register stage, then compare all outputs.
    task automatic apply(input logic [15:0] lo, input logic [15:0] hi, input logic [31:0] ew,
                         input logic eb, input logic ec, input string tag);
        in_valid = 1'b1; in_half = lo; in_upper = hi;
        @(posedge clk); @(negedge clk);
        n_run++;
        if (out_valid !== 1'b1 || out_word !== ew || out_illegal !== eb || out_compressed !== ec) begin
            n_fail++;
            $display("FAIL %s: in=%h got v=%b w=%h ill=%b c=%b exp v=1 w=%h ill=%b c=%b",
                     tag, lo, out_valid, out_word, out_illegal, out_compressed, ew, eb, ec);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; in_half = 16'h0001;
        @(posedge clk); @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_word !== 32'd0 || out_illegal !== 1'b0 || out_compressed !== 1'b0) begin
            n_fail++;
            $display("FAIL R14: reset got v=%b w=%h exp v=0 w=00000000", out_valid, out_word);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_valid();
        in_valid = 1'b0; in_half = 16'h0001;
        @(posedge clk); @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: out_valid got %b exp 0", out_valid);
        end
    endtask

    task automatic t_pass();
        apply(16'h0093, 16'h00a0, 32'h00a0_0093, 1'b0, 1'b0, "R1 pass A");
        apply(16'hffff, 16'h1234, 32'h1234_ffff, 1'b0, 1'b0, "R1 pass B");
    endtask

    task automatic t_q0();
        apply(c_spn(10'h3fc, 3'd7), 16'h0, e_i(12'h3fc, 5'd2, 3'd0, 5'd15, OI), 1'b0, 1'b1, "R4 R3 spn hi");
        apply(c_spn(10'h104, 3'd0), 16'h0, e_i(12'h104, 5'd2, 3'd0, 5'd8, OI), 1'b0, 1'b1, "R4 spn mix");
        apply(c_spn(10'h000, 3'd5), 16'h0, 32'd0, 1'b1, 1'b1, "R4 spn zero imm");
        apply(16'h0000, 16'hffff, 32'd0, 1'b1, 1'b1, "R4 all zero");
        apply(c_mem(3'b010, 7'h54, 3'd1, 3'd6), 16'h0, e_i(12'h054, 5'd9, 3'b010, 5'd14, LD), 1'b0, 1'b1, "R5 R3 lw");
        apply(c_mem(3'b110, 7'h44, 3'd7, 3'd0), 16'h0, e_s(12'h044, 5'd8, 5'd15), 1'b0, 1'b1, "R5 R3 sw");
    endtask

    task automatic t_q1_imm();
        apply(16'h0001, 16'h0, 32'h0000_0013, 1'b0, 1'b1, "R13 nop");
        apply(c_ci(3'b000, 1'b1, 5'd10, 5'b11101, 2'b01), 16'h0, e_i(12'hffd, 5'd10, 3'd0, 5'd10, OI), 1'b0, 1'b1, "R13 addi neg");
        apply(c_ci(3'b010, 1'b0, 5'd7, 5'd5, 2'b01), 16'h0, e_i(12'h005, 5'd0, 3'd0, 5'd7, OI), 1'b0, 1'b1, "R10 li");
        apply(c_ci(3'b010, 1'b0, 5'd0, 5'd5, 2'b01), 16'h0, 32'd0, 1'b1, 1'b1, "R10 li rd0");
        apply(c_ar(1'b0, 2'b00, 3'd2, 5'd31), 16'h0, e_i(12'h01f, 5'd10, 3'b101, 5'd10, OI), 1'b0, 1'b1, "R13 srli");
        apply(c_ar(1'b0, 2'b01, 3'd4, 5'd1), 16'h0, e_i(12'h401, 5'd12, 3'b101, 5'd12, OI), 1'b0, 1'b1, "R13 srai");
        apply(c_ar(1'b1, 2'b10, 3'd3, 5'd0), 16'h0, e_i(12'hfe0, 5'd11, 3'b111, 5'd11, OI), 1'b0, 1'b1, "R13 andi");
        apply(c_ar(1'b0, 2'b11, 3'd1, {2'b00, 3'd2}), 16'h0, e_r(7'h20, 5'd10, 5'd9, 3'b000, 5'd9), 1'b0, 1'b1, "R13 sub");
        apply(c_ar(1'b0, 2'b11, 3'd1, {2'b01, 3'd2}), 16'h0, e_r(7'h00, 5'd10, 5'd9, 3'b100, 5'd9), 1'b0, 1'b1, "R13 xor");
        apply(c_ar(1'b0, 2'b11, 3'd6, {2'b10, 3'd5}), 16'h0, e_r(7'h00, 5'd13, 5'd14, 3'b110, 5'd14), 1'b0, 1'b1, "R13 or");
        apply(c_ar(1'b0, 2'b11, 3'd6, {2'b11, 3'd5}), 16'h0, e_r(7'h00, 5'd13, 5'd14, 3'b111, 5'd14), 1'b0, 1'b1, "R13 and");
    endtask

    task automatic t_q1_flow();
        apply(c_jmp(3'b101, 12'h802), 16'h0, e_j({{9{1'b1}}, 12'h802}, 5'd0), 1'b0, 1'b1, "R6 j neg");
        apply(c_jmp(3'b001, 12'h5aa), 16'h0, e_j({9'd0, 12'h5aa}, 5'd1), 1'b0, 1'b1, "R6 jal pos");
        apply(c_br(3'b110, 9'h1fe, 3'd3), 16'h0, e_b({4'hf, 9'h1fe}, 5'd11, 3'b000), 1'b0, 1'b1, "R7 beqz neg");
        apply(c_br(3'b111, 9'h0aa, 3'd5), 16'h0, e_b({4'h0, 9'h0aa}, 5'd13, 3'b001), 1'b0, 1'b1, "R7 bnez pos");
    endtask

    task automatic t_q1_upper();
        apply(c_sp16(10'h3f0), 16'h0, e_i(12'hff0, 5'd2, 3'd0, 5'd2, OI), 1'b0, 1'b1, "R8 sp adjust neg");
        apply(c_sp16(10'h1b0), 16'h0, e_i(12'h1b0, 5'd2, 3'd0, 5'd2, OI), 1'b0, 1'b1, "R8 sp adjust pos");
        apply(c_ci(3'b011, 1'b1, 5'd3, 5'd1, 2'b01), 16'h0, {20'hfffe1, 5'd3, LU}, 1'b0, 1'b1, "R8 lui");
        apply(c_ci(3'b011, 1'b0, 5'd0, 5'd1, 2'b01), 16'h0, 32'd0, 1'b1, 1'b1, "R8 lui rd0");
        apply(c_ci(3'b011, 1'b0, 5'd5, 5'd0, 2'b01), 16'h0, 32'd0, 1'b1, 1'b1, "R8 lui imm0");
    endtask

    task automatic t_q2();
        apply(c_ci(3'b000, 1'b0, 5'd5, 5'd7, 2'b10), 16'h0, e_i(12'h007, 5'd5, 3'b001, 5'd5, OI), 1'b0, 1'b1, "R10 slli");
        apply(c_ci(3'b000, 1'b0, 5'd0, 5'd7, 2'b10), 16'h0, 32'd0, 1'b1, 1'b1, "R10 slli rd0");
        apply(c_lwsp(8'hb4, 5'd9), 16'h0, e_i(12'h0b4, 5'd2, 3'b010, 5'd9, LD), 1'b0, 1'b1, "R11 lwsp");
        apply(c_swsp(8'h84, 5'd31), 16'h0, e_s(12'h084, 5'd31, 5'd2), 1'b0, 1'b1, "R11 swsp");
        apply(c_ci(3'b100, 1'b0, 5'd6, 5'd0, 2'b10), 16'h0, e_i(12'd0, 5'd6, 3'd0, 5'd0, JR), 1'b0, 1'b1, "R9 jr");
        apply(c_ci(3'b100, 1'b0, 5'd8, 5'd9, 2'b10), 16'h0, e_r(7'd0, 5'd9, 5'd0, 3'd0, 5'd8), 1'b0, 1'b1, "R9 mv");
        apply(16'h9002, 16'h0, 32'h0010_0073, 1'b0, 1'b1, "R9 ebreak");
        apply(c_ci(3'b100, 1'b1, 5'd1, 5'd0, 2'b10), 16'h0, e_i(12'd0, 5'd1, 3'd0, 5'd1, JR), 1'b0, 1'b1, "R9 jalr");
        apply(c_ci(3'b100, 1'b1, 5'd10, 5'd11, 2'b10), 16'h0, e_r(7'd0, 5'd11, 5'd10, 3'd0, 5'd10), 1'b0, 1'b1, "R9 add");
    endtask

    task automatic t_illegal();
        apply(16'h2000 | 16'h0444, 16'h0, 32'd0, 1'b1, 1'b1, "R12 q0 fp load");
        apply(c_ar(1'b1, 2'b11, 3'd1, {2'b01, 3'd2}), 16'h0, 32'd0, 1'b1, 1'b1, "R12 wide add");
        apply(c_ar(1'b1, 2'b00, 3'd2, 5'd3), 16'h0, 32'd0, 1'b1, 1'b1, "R12 srli bit12");
        apply(c_ci(3'b000, 1'b1, 5'd5, 5'd3, 2'b10), 16'h0, 32'd0, 1'b1, 1'b1, "R12 slli bit12");
        apply(c_ci(3'b011, 1'b0, 5'd4, 5'd4, 2'b10), 16'h0, 32'd0, 1'b1, 1'b1, "R12 q2 fp load");
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_q0();
        t_q1_imm();
        t_q1_flow();
        t_q1_upper();
        t_q2();
        t_illegal();
        t_valid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule